// File: doc/BRIEF.md
# Lockable Double-Buffered PWM Channel

This block is one pulse-width modulated output with a small register file behind a plain write/read bus. Software programs a period and a duty value, both counted in ticks of a slow time base, and a control word that turns the channel on, picks the output mode and sets two polarity fields. The time base is the input clock divided by a fixed prescale ratio. The waveform is left-aligned: every period begins with the duty portion.

Period, duty and both polarity fields are written into shadow storage and copied into the active copies that shape the waveform. While the lock flag is clear, the copy happens at each period wrap. While it is set, the active copies are frozen, so software can stage a whole new setting. Clearing the flag then makes every staged field take effect at the same period boundary. Turning the channel on from idle copies the shadows at once, locked or not, and the count starts from zero.

Top module: `pwm_channel`

## Requirements
- R1: Each counter value lasts PRESCALE input clock cycles, so a period value P gives an output period of P*PRESCALE clock cycles.
- R2: While running with period P and duty D (0 < D < P), the output is at the duty level for the first D ticks of each period and at the opposite level for the remaining P-D ticks.
- R3: While control bit 6 (lock) is set, writes to period, duty and control bits 3 and 4 do not alter the waveform being generated.
- R4: After lock is cleared, the staged period, duty and duty polarity all take effect together from the next period boundary.
- R5: Control bit 3 sets the level driven during the duty portion and bit 4 sets the level driven when inactive, with 1 meaning high. The two fields are independent.
- R6: After reset the control register reads 0x038, period and duty read 0, and the output is high.
- R7: The channel runs only when control bit 0 is 1 and bits 2:1 are 00 (left-aligned). Otherwise the output sits at the inactive level given by bit 4.
- R8: Enabling from idle loads the shadow values at once, even with lock set. The first period starts at count 0 in the duty level.
- R9: A duty of 0 gives a constant opposite-of-duty level. A duty equal to or above the period gives a constant duty level.
- R10: A period of 0 holds the running output at the inactive level.
- R11: Register addresses are 0 for control, 1 for period and 2 for duty. Address 3 reads 0. Control bit 5 always reads 1, bit 7 and bits above 8 read 0, and bit 8 (low-power disable) is stored and reads back. Period and duty read back the last written, staged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench builds the block with PRESCALE set to 3 and CNT_W set to 8, so every count spans more than one clock. An off-by-one in the tick divider then shows up as a wrong run length instead of hiding behind a ratio of 1. The 8-bit counter lets a duty of 200 against a period of 4 exercise the duty-above-period case cheaply. It also keeps every lock, unlock and period-zero scenario within a few dozen cycles.

// File: rtl/pwm_pkg.sv
// Package: shared control-word layout, register addresses and control type
// for the PWM channel. Assumes a bus word of at least 9 bits.
package pwm_pkg;
    localparam int CTL_EN   = 0;
    localparam int CTL_MLO  = 1;
    localparam int CTL_MHI  = 2;
    localparam int CTL_DPOL = 3;
    localparam int CTL_IPOL = 4;
    localparam int CTL_AON  = 5;
    localparam int CTL_LOCK = 6;
    localparam int CTL_LPD  = 8;

    localparam logic [1:0] MODE_LEFT = 2'b00;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_PERIOD = 2'd1,
        ADDR_DUTY   = 2'd2,
        ADDR_NONE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       lpd;
        logic       lock;
        logic       ipol;
        logic       dpol;
        logic [1:0] mode;
        logic       en;
    } ctrl_t;
endpackage

// File: rtl/pwm_regfile.sv
// Module: pwm_regfile
// Holds the control word and the staged (shadow) period and duty values and
// serves reads. Assumes DATA_W >= 9 and DATA_W >= CNT_W.
module pwm_regfile
    import pwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  sh_period,
    output logic [CNT_W-1:0]  sh_duty
);
    // Register writes; reset gives both polarity fields positive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl      <= '{lpd: 1'b0, lock: 1'b0, ipol: 1'b1, dpol: 1'b1,
                           mode: MODE_LEFT, en: 1'b0};
            sh_period <= '0;
            sh_duty   <= '0;
        end else if (bus_we) begin
            case (reg_addr_e'(bus_addr))
                ADDR_CTRL: begin
                    ctrl.en   <= bus_wdata[CTL_EN];
                    ctrl.mode <= bus_wdata[CTL_MHI:CTL_MLO];
                    ctrl.dpol <= bus_wdata[CTL_DPOL];
                    ctrl.ipol <= bus_wdata[CTL_IPOL];
                    ctrl.lock <= bus_wdata[CTL_LOCK];
                    ctrl.lpd  <= bus_wdata[CTL_LPD];
                end
                ADDR_PERIOD: sh_period <= bus_wdata[CNT_W-1:0];
                ADDR_DUTY:   sh_duty   <= bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Read mux; the always-on bit reads as one.
    always_comb begin
        bus_rdata = '0;
        case (reg_addr_e'(bus_addr))
            ADDR_CTRL: begin
                bus_rdata[CTL_EN]          = ctrl.en;
                bus_rdata[CTL_MHI:CTL_MLO] = ctrl.mode;
                bus_rdata[CTL_DPOL]        = ctrl.dpol;
                bus_rdata[CTL_IPOL]        = ctrl.ipol;
                bus_rdata[CTL_AON]         = 1'b1;
                bus_rdata[CTL_LOCK]        = ctrl.lock;
                bus_rdata[CTL_LPD]         = ctrl.lpd;
            end
            ADDR_PERIOD: bus_rdata[CNT_W-1:0] = sh_period;
            ADDR_DUTY:   bus_rdata[CNT_W-1:0] = sh_duty;
            default: ;
        endcase
    end
endmodule

// File: rtl/pwm_prescaler.sv
// Module: pwm_prescaler
// Divides the input clock into one-cycle tick pulses, one every PRESCALE
// cycles while run is high. Held at phase zero while idle. Assumes PRESCALE >= 1.
module pwm_prescaler #(
    parameter int PRESCALE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] phase;

    // Phase counter, cleared whenever the channel is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)    phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + PW'(1);
    end

    assign tick = run && (phase == LAST);

    a_r1_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(phase) < PRESCALE);
endmodule

// File: rtl/pwm_core.sv
// Module: pwm_core
// Active (working) copies of period, duty and polarity, the tick counter and
// the left-aligned output decode. Shadows load on start from idle or, with
// lock clear, at each period wrap. Assumes tick comes from a prescaler driven
// by run_q.
module pwm_core
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] sh_period,
    input  logic [CNT_W-1:0] sh_duty,
    input  logic             tick,
    output logic             run_q,
    output logic             pwm_out
);
    logic [CNT_W-1:0] act_period, act_duty, cnt;
    logic             act_dpol, act_ipol;
    logic             want_run, start, last, wrap, load;

    assign want_run = ctrl.en && (ctrl.mode == MODE_LEFT);
    assign start    = want_run && !run_q;
    assign last     = (act_period == '0) || (cnt >= act_period - CNT_W'(1));
    assign wrap     = run_q && tick && last;
    assign load     = start || (wrap && !ctrl.lock);

    // Running flag follows the enable fields one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= want_run;
    end

    // Active copies of the staged settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_period <= '0;
            act_duty   <= '0;
            act_dpol   <= 1'b1;
            act_ipol   <= 1'b1;
        end else if (load) begin
            act_period <= sh_period;
            act_duty   <= sh_duty;
            act_dpol   <= ctrl.dpol;
            act_ipol   <= ctrl.ipol;
        end
    end

    // Tick counter within the period, restarted on start and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_q || start) cnt <= '0;
        else if (tick) cnt <= last ? '0 : cnt + CNT_W'(1);
    end

    // Left-aligned output decode.
    always_comb begin
        if (!run_q)                 pwm_out = ctrl.ipol;
        else if (act_period == '0)  pwm_out = act_ipol;
        else if (cnt < act_duty)    pwm_out = act_dpol;
        else                        pwm_out = !act_dpol;
    end

    a_r3_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl.lock) && $past(run_q) && run_q) |->
        ($stable(act_period) && $stable(act_duty) && $stable(act_dpol)));

    a_r1_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_q) && run_q && !$past(tick)) |-> $stable(cnt));

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && act_period != '0) |-> (cnt < act_period));

    a_r8_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> (cnt == '0));
endmodule

// File: rtl/pwm_channel.sv
// Module: pwm_channel (top)
// Single PWM channel: register file, prescaler and core. Assumes DATA_W >= 9
// and DATA_W >= CNT_W; the bus accepts one write per cycle with no wait state.
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int PRESCALE = 2,
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] sh_period, sh_duty;
    logic             run_q, tick;

    pwm_regfile #(.CNT_W(CNT_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl(ctrl),
        .sh_period(sh_period), .sh_duty(sh_duty)
    );

    pwm_prescaler #(.PRESCALE(PRESCALE)) presc_i (
        .clk(clk), .rst_n(rst_n), .run(run_q), .tick(tick)
    );

    pwm_core #(.CNT_W(CNT_W)) core_i (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .sh_period(sh_period),
        .sh_duty(sh_duty), .tick(tick), .run_q(run_q), .pwm_out(pwm_out)
    );

    a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (pwm_out == ctrl.ipol));
endmodule

// File: tb/pwm_channel_tb_top.sv
module pwm_channel_tb_top;
    localparam int PRESC  = 3;
    localparam int CNT_W  = 8;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [1:0]        bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              pwm_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    pwm_channel #(.PRESCALE(PRESC), .CNT_W(CNT_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #10 clk = ~clk;

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog all-reqs actual=%0d cycles expected<50000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = DATA_W'(d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] a, input int exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(int'(bus_rdata) == exp, tag, int'(bus_rdata), exp);
    endtask

    // Samples one cycle after each edge following an enable write and
    // compares against the left-aligned pattern.
    task automatic pattern(input int p, input int d, input bit dl, input int n, input string tag);
        int bad = 0;
        int first_act = 0;
        int first_exp = 0;
        @(posedge clk);
        for (int i = 1; i <= n; i++) begin
            bit e;
            @(negedge clk);
            e = (((i - 1) / PRESC) % p < d) ? dl : !dl;
            if (pwm_out !== e && bad == 0) begin first_act = int'(pwm_out); first_exp = int'(e); end
            if (pwm_out !== e) bad++;
        end
        check(bad == 0, tag, first_act, first_exp);
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out === 1'b1) h++;
        end
    endtask

    task automatic const_level(input int n, input bit lvl, input string tag);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out !== lvl) bad++;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic go_idle();
        wr(2'd0, 'h018);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        rd_check(2'd0, 'h038, "R6 ctrl reset");
        rd_check(2'd1, 0, "R6 period reset");
        rd_check(2'd2, 0, "R6 duty reset");
        check(pwm_out === 1'b1, "R6 output reset", int'(pwm_out), 1);
    endtask

    task automatic t_regmap();
        wr(2'd1, 'h55);
        rd_check(2'd1, 'h55, "R11 period readback");
        wr(2'd2, 'h2a);
        rd_check(2'd2, 'h2a, "R11 duty readback");
        rd_check(2'd3, 0, "R11 unused address");
        wr(2'd0, 'hFFFF);
        rd_check(2'd0, 'h17F, "R11 ctrl readback");
        wr(2'd0, 'h0007);
        rd_check(2'd0, 'h027, "R11 ctrl lpd clear");
        const_level(10, 1'b0, "R7 mode 11 stays idle low");
        wr(2'd0, 'h0017);
        const_level(10, 1'b1, "R7 mode 11 stays idle high");
        go_idle();
    endtask

    task automatic t_basic();
        wr(2'd1, 4); wr(2'd2, 1);
        wr(2'd0, 'h019);
        pattern(4, 1, 1'b1, 4 * PRESC * 2, "R1 R2 R8 left-aligned p4 d1");
        go_idle();
        wr(2'd1, 7); wr(2'd2, 3);
        wr(2'd0, 'h019);
        pattern(7, 3, 1'b1, 7 * PRESC * 2, "R1 R2 left-aligned p7 d3");
        go_idle();
    endtask

    task automatic t_polarity();
        wr(2'd1, 5); wr(2'd2, 2);
        wr(2'd0, 'h011);
        pattern(5, 2, 1'b0, 5 * PRESC * 2, "R5 duty level low");
        wr(2'd0, 'h000);
        repeat (2) @(negedge clk);
        const_level(6, 1'b0, "R5 R7 inactive low when disabled");
        wr(2'd0, 'h010);
        repeat (2) @(negedge clk);
        const_level(6, 1'b1, "R5 R7 inactive high when disabled");
    endtask

    task automatic t_edges();
        wr(2'd1, 4); wr(2'd2, 0);
        wr(2'd0, 'h019);
        repeat (2) @(negedge clk);
        const_level(24, 1'b0, "R9 duty zero");
        go_idle();
        wr(2'd2, 4);
        wr(2'd0, 'h019);
        repeat (2) @(negedge clk);
        const_level(24, 1'b1, "R9 duty equals period");
        go_idle();
        wr(2'd2, 200);
        wr(2'd0, 'h011);
        repeat (2) @(negedge clk);
        const_level(24, 1'b0, "R9 duty above period");
        go_idle();
        wr(2'd1, 0); wr(2'd2, 3);
        wr(2'd0, 'h009);
        repeat (2) @(negedge clk);
        const_level(24, 1'b0, "R10 period zero inactive");
        go_idle();
    endtask

    task automatic t_lock();
        int h;
        wr(2'd1, 4); wr(2'd2, 1);
        wr(2'd0, 'h019);
        wr(2'd0, 'h059);
        wr(2'd1, 6); wr(2'd2, 5);
        wr(2'd0, 'h051);
        rd_check(2'd1, 6, "R11 staged period visible");
        count_high(4 * PRESC * 2, h);
        check(h == 2 * PRESC, "R3 locked waveform held", h, 2 * PRESC);
        wr(2'd0, 'h011);
        repeat (4 * PRESC) @(negedge clk);
        count_high(6 * PRESC * 2, h);
        check(h == 2 * PRESC, "R4 settings switch together", h, 2 * PRESC);
        go_idle();
        wr(2'd0, 'h058);
        wr(2'd1, 3); wr(2'd2, 2);
        wr(2'd0, 'h059);
        pattern(3, 2, 1'b1, 3 * PRESC * 2, "R8 locked enable loads at once");
        go_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_basic();
        t_polarity();
        t_edges();
        t_lock();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule